// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a two-port RAM. It watches the address and control pins of both ports. It reserves the two highest addresses as mailboxes and drives one active-low interrupt line per port. Each port owns one mailbox. When the far port writes into a mailbox, the owner's interrupt is raised. When the owner reads its own mailbox, the interrupt is dropped. The message word itself is ordinary RAM data, and this block neither stores nor inspects it.

A busy input from the external arbiter qualifies each port. While a port is told it is busy, its accesses have no effect on the flags: it cannot raise the other port's interrupt and it cannot clear its own. Both flags are registers on a single clock with a synchronous reset. An access presented in one cycle shows on the interrupt pins after the next rising edge.

Top module: `mbx_irq_top`

## Requirements
- R1: With an address width of ADDR_W, the right port's mailbox is at address 2^ADDR_W-1 (all ones) and the left port's mailbox is at 2^ADDR_W-2. No other address affects either flag.
- R2: A left-port write to the right mailbox drives r_irq_n low after the next clock edge. A write is counted when ce_n=0, rw=0 and busy_n=1 in the same cycle; oe_n does not matter for a write.
- R3: A right-port write to the left mailbox drives l_irq_n low after the next clock edge, under the same write conditions as R2.
- R4: An owner read of its own mailbox drives its interrupt high after the next clock edge. A read needs ce_n=0, rw=1, oe_n=0 and busy_n=1 in the same cycle.
- R5: Reading the other port's mailbox leaves both interrupt outputs unchanged.
- R6: While a port's busy_n is 0, its write to the other mailbox does not assert the other port's interrupt.
- R7: While a port's busy_n is 0, its read of its own mailbox does not release its interrupt.
- R8: An access with ce_n=1 has no effect. A read with oe_n=1 has no effect.
- R9: A synchronous reset (rst=1 at a clock edge) drives both l_irq_n and r_irq_n high.
- R10: If a set and a clear of the same flag arrive in the same cycle, the set wins and the interrupt is low after the edge.
- R11: A port writing its own mailbox, or any port writing a non-mailbox address, leaves both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_addr | input | ADDR_W | Left port address |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left direction: 1 means read, 0 means write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy from the arbiter, active low |
| r_addr | input | ADDR_W | Right port address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right direction: 1 means read, 0 means write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy from the arbiter, active low |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The vector table walks each flag through set, hold and clear. Between those steps it applies near misses, each differing from a real event in one pin: chip enable released, output enable released, busy asserted, or the wrong mailbox address. This separates a correct decode from one that ignores that pin. Reads of the far mailbox, and writes to the own mailbox or to an unrelated address, show that only the intended address and direction pairs reach each flag. Same-cycle set and clear on both flags confirms the priority. A final reset applied with both flags low confirms that they return high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

   typedef struct packed {
      logic far_wr;   // qualified write into the other port's mailbox
      logic own_rd;   // qualified read of this port's own mailbox
   } mbx_evt_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_pkg::*;
#(
   parameter int    ADDR_W = 15,
   parameter side_e SIDE   = SIDE_L
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              rw,
   input  logic              oe_n,
   input  logic              busy_n,
   output mbx_evt_t          evt
);
   localparam logic [ADDR_W-1:0] TOP_A  = '1;
   localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;
   localparam logic [ADDR_W-1:0] OWN_A  = (SIDE == SIDE_R) ? TOP_A  : NEXT_A;
   localparam logic [ADDR_W-1:0] FAR_A  = (SIDE == SIDE_R) ? NEXT_A : TOP_A;

   logic granted;
   logic wr_cyc;
   logic rd_cyc;

   always_comb begin
      granted    = !ce_n && busy_n;
      wr_cyc     = granted && !rw;
      rd_cyc     = granted && rw && !oe_n;
      evt.far_wr = wr_cyc && (addr == FAR_A);
      evt.own_rd = rd_cyc && (addr == OWN_A);
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_req,
   input  logic clr_req,
   output logic irq_n
);
   always_ff @(posedge clk) begin
      if (rst)          irq_n <= 1'b1;
      else if (set_req) irq_n <= 1'b0;
      else if (clr_req) irq_n <= 1'b1;
   end

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_req |=> !irq_n);

   // R4
   clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_req && !set_req) |=> irq_n);

   // R11
   flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_req && !clr_req) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_ce_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic              l_busy_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_ce_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic              r_busy_n,
   output logic              l_irq_n,
   output logic              r_irq_n
);
   localparam int NPORT = 2;
   localparam logic [ADDR_W-1:0] R_MBX = '1;
   localparam logic [ADDR_W-1:0] L_MBX = R_MBX - 1'b1;

   if (ADDR_W < 2) begin : g_bad_width
      $error("mbx_irq_top: ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] addr_a [NPORT];
   logic [NPORT-1:0]  ce_a, rw_a, oe_a, busy_a, irq_a;
   mbx_evt_t          evt_a  [NPORT];

   always_comb begin
      addr_a[0] = l_addr;  addr_a[1] = r_addr;
      ce_a   = {r_ce_n,   l_ce_n};
      rw_a   = {r_rw,     l_rw};
      oe_a   = {r_oe_n,   l_oe_n};
      busy_a = {r_busy_n, l_busy_n};
   end

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      mbx_port_decode #(
         .ADDR_W (ADDR_W),
         .SIDE   (side_e'(g))
      ) u_dec (
         .addr   (addr_a[g]),
         .ce_n   (ce_a[g]),
         .rw     (rw_a[g]),
         .oe_n   (oe_a[g]),
         .busy_n (busy_a[g]),
         .evt    (evt_a[g])
      );

      mbx_flag u_flag (
         .clk     (clk),
         .rst     (rst),
         .set_req (evt_a[NPORT-1-g].far_wr),
         .clr_req (evt_a[g].own_rd),
         .irq_n   (irq_a[g])
      );
   end

   assign l_irq_n = irq_a[0];
   assign r_irq_n = irq_a[1];

   // R2
   left_sets_right_chk: assert property (@(posedge clk) disable iff (rst)
      (!l_ce_n && !l_rw && l_busy_n && l_addr == R_MBX) |=> !r_irq_n);

   // R3
   right_sets_left_chk: assert property (@(posedge clk) disable iff (rst)
      (!r_ce_n && !r_rw && r_busy_n && r_addr == L_MBX) |=> !l_irq_n);

   // R6
   busy_r_no_set_chk: assert property (@(posedge clk) disable iff (rst)
      !r_busy_n |=> !$fell(l_irq_n));

   // R7
   busy_l_no_clr_chk: assert property (@(posedge clk) disable iff (rst)
      !l_busy_n |=> !$rose(l_irq_n));

   // R8
   idle_ports_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (l_ce_n && r_ce_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/sim_mbx_irq_top.sv
module sim_mbx_irq_top;
   localparam int AW = 15;
   localparam logic [AW-1:0] RM = '1;
   localparam logic [AW-1:0] LM = RM - 1'b1;
   localparam logic [AW-1:0] OA = 15'h0005;
   localparam int NV = 16;

   typedef struct packed {
      logic [AW-1:0] la; logic lce, lrw, loe, lbz;
      logic [AW-1:0] ra; logic rce, rrw, roe, rbz;
      logic el, er;
   } tv_t;

   // fields: la,lce_n,lrw,loe_n,lbusy_n, ra,rce_n,rrw,roe_n,rbusy_n, exp_l,exp_r
   localparam tv_t TBL [NV] = '{
      '{OA,1'b1,1'b1,1'b1,1'b1, OA,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1}, // R8 idle
      '{RM,1'b0,1'b0,1'b1,1'b1, OA,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0}, // R2 R1 left writes right mbx
      '{RM,1'b0,1'b1,1'b0,1'b1, OA,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0}, // R5 left reads right mbx
      '{OA,1'b1,1'b1,1'b1,1'b1, RM,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0}, // R8 read with oe_n high
      '{OA,1'b1,1'b1,1'b1,1'b1, RM,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0}, // R7 read while busy
      '{OA,1'b1,1'b1,1'b1,1'b1, RM,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b1}, // R4 owner read clears
      '{OA,1'b1,1'b1,1'b1,1'b1, LM,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1}, // R6 write while busy
      '{OA,1'b1,1'b1,1'b1,1'b1, LM,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1}, // R8 write with ce_n high
      '{OA,1'b1,1'b1,1'b1,1'b1, LM,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1}, // R3 right writes left mbx
      '{OA,1'b1,1'b1,1'b1,1'b1, LM,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1}, // R5 right reads left mbx
      '{LM,1'b0,1'b0,1'b1,1'b1, OA,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1}, // R11 owner writes own mbx
      '{OA,1'b0,1'b0,1'b1,1'b1, OA,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1}, // R11 non-mailbox writes
      '{LM,1'b0,1'b1,1'b0,1'b1, LM,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1}, // R10 set beats clear
      '{LM,1'b0,1'b1,1'b0,1'b1, OA,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1}, // R4 left clears
      '{RM,1'b0,1'b0,1'b1,1'b1, RM,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0}, // R10 set beats clear
      '{OA,1'b1,1'b1,1'b1,1'b1, RM,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b1}  // R4 right clears
   };
   localparam int REQ [NV] = '{8, 2, 5, 8, 7, 4, 6, 8, 3, 5, 11, 11, 10, 4, 10, 4};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [AW-1:0] l_addr = OA, r_addr = OA;
   logic l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
   logic r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
   logic l_irq_n, r_irq_n;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mbx_irq_top #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst(rst),
      .l_addr(l_addr), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
      .r_addr(r_addr), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
      .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
   );

   task automatic check(input int req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic apply(input tv_t v);
      l_addr = v.la; l_ce_n = v.lce; l_rw = v.lrw; l_oe_n = v.loe; l_busy_n = v.lbz;
      r_addr = v.ra; r_ce_n = v.rce; r_rw = v.rrw; r_oe_n = v.roe; r_busy_n = v.rbz;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(9, "l_irq_n after reset", l_irq_n, 1'b1);
      check(9, "r_irq_n after reset", r_irq_n, 1'b1);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         apply(TBL[i]);
         @(negedge clk);
         check(REQ[i], $sformatf("vec %0d l_irq_n", i), l_irq_n, TBL[i].el);
         check(REQ[i], $sformatf("vec %0d r_irq_n", i), r_irq_n, TBL[i].er);
      end
      // R9 raise both flags, then reset must release them
      l_addr = RM; l_ce_n = 1'b0; l_rw = 1'b0;
      r_addr = LM; r_ce_n = 1'b0; r_rw = 1'b0;
      @(negedge clk);
      check(9, "both low before reset l", l_irq_n, 1'b0);
      check(9, "both low before reset r", r_irq_n, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      check(9, "l_irq_n reset with flag low", l_irq_n, 1'b1);
      check(9, "r_irq_n reset with flag low", r_irq_n, 1'b1);
      l_ce_n = 1'b1; r_ce_n = 1'b1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule